// File: doc/BRIEF.md
# Fully Associative LRU Translation Cache

This block holds recently used page translations so that most address translations skip the page-table walk. A requester presents a virtual page number on a valid/ready lookup channel. If any valid entry holds that page, the block reports a hit and returns the stored physical frame number combinationally, in the same cycle. If no entry holds it, the block reports a miss and starts a walk request. It stops accepting lookups until the walker answers.

A successful walk installs the translation. The slot used is the lowest-numbered empty slot, or, when every slot is valid, the least recently used one. Hits and installs both make an entry the most recent. A walk that reports a missing page is passed on as a fault pulse and is not installed. The requester brings the page in and then repeats the lookup. A flush input empties the cache in one cycle.

Back-pressure rules: a lookup is taken only in a cycle where `lk_valid` and `lk_ready` are both high. Once `wk_req_valid` is raised, it stays high and `wk_req_vpn` stays unchanged until the cycle in which `wk_req_ready` is sampled high. The walker response has no ready signal, because the block always accepts it while waiting for it.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` is 1, and the first lookup of any page misses.
- R2: A lookup that matches a valid entry raises `lk_hit` in the same cycle with `lk_pfn` equal to the stored frame, and it raises no walk request.
- R3: A lookup that matches no valid entry raises `lk_miss` in the same cycle. From the next cycle, `wk_req_valid` is high with `wk_req_vpn` equal to the missed page, and `lk_ready` stays low until the cycle after the walker response.
- R4: A walker response with `wk_rsp_fault`=0 installs the page with `wk_rsp_pfn`. A later lookup of that page hits with that frame.
- R5: A walker response with `wk_rsp_fault`=1 raises `fault_out` in that same cycle and installs nothing, so a repeated lookup of that page misses again.
- R6: Empty entries are filled before any valid entry is evicted. After ENTRIES distinct successful fills from empty, all ENTRIES pages hit.
- R7: When all entries are valid, a fill replaces the entry whose last hit or fill is oldest.
- R8: A flush clears every entry in one cycle and holds `lk_ready` low during that cycle. If the flush comes while a walk is outstanding, the walk's result is discarded.
- R9: `multi_hit` is high whenever more than one valid entry matches the presented page. Because installs happen only after a miss, it stays low in normal use.
- R10: While `wk_req_valid` is high and `wk_req_ready` is low, the request and its page number hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup presented |
| lk_ready | output | 1 | Lookup can be taken |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Taken lookup hit |
| lk_miss | output | 1 | Taken lookup missed; a walk follows |
| lk_pfn | output | PFN_W | Frame for a hit, 0 otherwise |
| wk_req_valid | output | 1 | Walk request pending |
| wk_req_ready | input | 1 | Walker takes the request |
| wk_req_vpn | output | VPN_W | Page to walk |
| wk_rsp_valid | input | 1 | Walk result present |
| wk_rsp_fault | input | 1 | Walk found the page absent |
| wk_rsp_pfn | input | PFN_W | Frame from the walk |
| fault_out | output | 1 | Fault passed through from the walker |
| multi_hit | output | 1 | More than one valid entry matched |

## Verification
The bench builds the cache with ENTRIES=4 and 20-bit page and frame numbers. This lets a few thousand lookups over a pool of six pages push every entry through fill, hit, and eviction many times. Each hit/miss result is compared with a timestamp model of least-recent use. With frames derived arithmetically from page numbers, every returned frame is checked exactly. Faults, flushes from idle, flushes during an outstanding walk, and walk-request back-pressure are each driven at specific points within that small configuration.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]   tags [ENTRIES],
  input  logic [VPN_W-1:0]   key,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic               multi
);
  logic [ENTRIES-1:0] hv;
  logic [IW:0]        cnt;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hv[g] = vld[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    cnt = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (hv[j]) idx = IW'(j);
      cnt = cnt + (IW + 1)'(hv[j]);
    end
  end

  assign any   = |hv;
  assign multi = cnt > (IW + 1)'(1);
endmodule

// File: rtl/xlat_recency.sv
module xlat_recency #(
  parameter int ENTRIES = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               touch,
  input  logic [IW-1:0]      touch_idx,
  input  logic [ENTRIES-1:0] vld,
  output logic [IW-1:0]      victim
);
  // rank 0 = most recent, ENTRIES-1 = least recent; ranks stay a permutation
  logic [IW-1:0] rank [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) rank[j] <= IW'(j);
    end else if (clear) begin
      for (int j = 0; j < ENTRIES; j++) rank[j] <= IW'(j);
    end else if (touch) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IW'(j) == touch_idx)            rank[j] <= '0;
        else if (rank[j] < rank[touch_idx]) rank[j] <= rank[j] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (!vld[j] && !found) begin
        victim = IW'(j);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int j = 0; j < ENTRIES; j++)
        if (rank[j] == IW'(ENTRIES - 1)) victim = IW'(j);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             wk_req_valid,
  input  logic             wk_req_ready,
  output logic [VPN_W-1:0] wk_req_vpn,
  input  logic             wk_rsp_valid,
  input  logic             wk_rsp_fault,
  input  logic [PFN_W-1:0] wk_rsp_pfn,
  output logic             fault_out,
  output logic             multi_hit
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag   [ENTRIES];
  logic [PFN_W-1:0]   frame [ENTRIES];
  walk_st_e           st;
  logic [VPN_W-1:0]   pend_vpn;
  logic               stale;

  logic               any;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      victim;
  logic               accept, install;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .vld(vld), .tags(tag), .key(lk_vpn),
    .any(any), .idx(hit_idx), .multi(multi_hit)
  );

  xlat_recency #(.ENTRIES(ENTRIES)) u_recency (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .touch(lk_hit || install),
    .touch_idx(install ? victim : hit_idx),
    .vld(vld), .victim(victim)
  );

  assign lk_ready     = (st == ST_IDLE) && !flush;
  assign accept       = lk_valid && lk_ready;
  assign lk_hit       = accept && any;
  assign lk_miss      = accept && !any;
  assign lk_pfn       = lk_hit ? frame[hit_idx] : '0;
  assign wk_req_valid = (st == ST_REQ);
  assign wk_req_vpn   = pend_vpn;
  assign fault_out    = (st == ST_WAIT) && wk_rsp_valid && wk_rsp_fault;
  assign install      = (st == ST_WAIT) && wk_rsp_valid && !wk_rsp_fault
                        && !stale && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pend_vpn <= '0;
      stale    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (lk_miss) begin
          st       <= ST_REQ;
          pend_vpn <= lk_vpn;
          stale    <= 1'b0;
        end
        ST_REQ: begin
          if (flush)        stale <= 1'b1;
          if (wk_req_ready) st    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (flush)        stale <= 1'b1;
          if (wk_rsp_valid) st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld <= '0;
    else if (flush)   vld <= '0;
    else if (install) vld[victim] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag[victim]   <= pend_vpn;
      frame[victim] <= wk_rsp_pfn;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             wk_req_valid,
  input logic             wk_req_ready,
  input logic [VPN_W-1:0] wk_req_vpn,
  input logic             wk_rsp_valid,
  input logic             wk_rsp_fault,
  input logic             fault_out,
  input logic             multi_hit
);
  p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !wk_req_valid && !lk_miss);

  p_miss_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> wk_req_valid && !lk_ready);

  p_fault_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |-> wk_rsp_valid && wk_rsp_fault);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !multi_hit);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wk_req_valid && !wk_req_ready |=> wk_req_valid && $stable(wk_req_vpn));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready),
  .wk_req_vpn(wk_req_vpn), .wk_rsp_valid(wk_rsp_valid),
  .wk_rsp_fault(wk_rsp_fault), .fault_out(fault_out), .multi_hit(multi_hit)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int N = 4;
  localparam int VW = 20;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, lk_valid = 1'b0, wk_req_ready = 1'b0;
  logic wk_rsp_valid = 1'b0, wk_rsp_fault = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [PW-1:0] wk_rsp_pfn = '0;
  logic lk_ready, lk_hit, lk_miss, wk_req_valid, fault_out, multi_hit;
  logic [PW-1:0] lk_pfn;
  logic [VW-1:0] wk_req_vpn;

  always #10 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pfn(lk_pfn), .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready),
    .wk_req_vpn(wk_req_vpn), .wk_rsp_valid(wk_rsp_valid),
    .wk_rsp_fault(wk_rsp_fault), .wk_rsp_pfn(wk_rsp_pfn),
    .fault_out(fault_out), .multi_hit(multi_hit)
  );

  int checks = 0;
  int failures = 0;

  // reference: valid, page, last-use time; LRU = smallest time
  bit            m_vld [N];
  logic [VW-1:0] m_vpn [N];
  int            m_time[N];
  int            now = 0;

  function automatic logic [PW-1:0] pfn_of(input logic [VW-1:0] v);
    return PW'((v * 37 + 20'h01234) & 20'hFFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic void m_fill(input logic [VW-1:0] v);
    int s = -1;
    for (int i = 0; i < N; i++) if (!m_vld[i] && s < 0) s = i;
    if (s < 0) begin
      s = 0;
      for (int i = 1; i < N; i++) if (m_time[i] < m_time[s]) s = i;
    end
    m_vld[s] = 1; m_vpn[s] = v; now++; m_time[s] = now;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
  endfunction

  // one lookup; on miss serve the walk with one cycle of request back-pressure
  task automatic access(input logic [VW-1:0] v, input bit fault_it, input string req);
    int  e;
    bit  exp_hit;
    e = m_find(v);
    exp_hit = (e >= 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; #1;
    chk(lk_ready == 1, "R3 ready before lookup", lk_ready, 1);
    chk(lk_hit == exp_hit, req, lk_hit, exp_hit);
    chk(lk_miss == !exp_hit, req, lk_miss, !exp_hit);
    chk(multi_hit == 0, "R9 single match", multi_hit, 0);
    if (exp_hit) begin
      chk(lk_pfn == pfn_of(v), "R2 hit frame", lk_pfn, pfn_of(v));
      now++; m_time[e] = now;
    end
    @(negedge clk);
    lk_valid = 0;
    if (exp_hit) begin
      chk(wk_req_valid == 0, "R2 no walk on hit", wk_req_valid, 0);
    end else begin
      chk(wk_req_valid == 1 && wk_req_vpn == v, "R3 walk request", wk_req_vpn, v);
      chk(lk_ready == 0, "R3 busy during walk", lk_ready, 0);
      @(negedge clk);
      chk(wk_req_valid == 1 && wk_req_vpn == v, "R10 request held", wk_req_vpn, v);
      wk_req_ready = 1;
      @(negedge clk);
      wk_req_ready = 0;
      chk(wk_req_valid == 0, "R3 request taken", wk_req_valid, 0);
      @(negedge clk);
      wk_rsp_valid = 1; wk_rsp_fault = fault_it; wk_rsp_pfn = pfn_of(v); #1;
      chk(fault_out == fault_it, "R5 fault pass", fault_out, fault_it);
      chk(lk_ready == 0, "R3 busy until response", lk_ready, 0);
      @(negedge clk);
      wk_rsp_valid = 0; wk_rsp_fault = 0;
      if (!fault_it) m_fill(v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lk_ready == 1, "R1 ready after reset", lk_ready, 1);
    chk(wk_req_valid == 0 && fault_out == 0, "R1 idle outputs", wk_req_valid, 0);

    // R1 then R4/R6: fill every slot from empty and rehit all
    for (int p = 0; p < N; p++) access(VW'(p + 16), 0, "R1 R6 cold miss");
    for (int p = 0; p < N; p++) access(VW'(p + 16), 0, "R4 R6 resident hit");

    // R7: touch 16, then new page evicts 17 (oldest)
    access(VW'(16), 0, "R7 refresh hit");
    access(VW'(99), 0, "R7 new page miss");
    access(VW'(17), 0, "R7 oldest evicted");
    access(VW'(16), 0, "R7 refreshed kept");

    // R5: faulting walk installs nothing; retry after page brought in
    access(VW'(500), 1, "R5 first miss");
    access(VW'(500), 0, "R5 retry misses");
    access(VW'(500), 0, "R5 installed after retry");

    // R7 sweep over six pages
    seed = 32'h1357;
    for (int k = 0; k < 3000; k++) begin
      seed = seed * 1103515245 + 12345;
      access(VW'(((seed >> 16) % 6) * 4099 + 3), 0, "R7 sweep");
    end

    // R8: flush from idle
    @(negedge clk); flush = 1; #1;
    chk(lk_ready == 0, "R8 not ready in flush", lk_ready, 0);
    @(negedge clk); flush = 0;
    m_clear();
    for (int p = 0; p < 6; p++) access(VW'(p * 4099 + 3), 0, "R8 miss after flush");

    // R8: flush while walk outstanding discards its result
    @(negedge clk); lk_valid = 1; lk_vpn = VW'(777); #1;
    chk(lk_miss == 1, "R8 walk start", lk_miss, 1);
    @(negedge clk); lk_valid = 0; wk_req_ready = 1;
    @(negedge clk); wk_req_ready = 0; flush = 1;
    @(negedge clk); flush = 0;
    wk_rsp_valid = 1; wk_rsp_pfn = pfn_of(VW'(777));
    @(negedge clk); wk_rsp_valid = 0;
    m_clear();
    access(VW'(777), 0, "R8 stale fill dropped");
    access(VW'(777), 0, "R8 fill after refetch");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule